// File: doc/BRIEF.md
# Configurable 8-bit Waveform Timer

This block is an up/down counter with one compare channel that produces a waveform on a single output. A control byte selects one of four counting modes, an action for the compare output and a clock-enable tap. A small register port writes the control byte, the compare value and the flag-clear mask, and reads back the control byte, the compare value, the live count and the two flags.

The counter advances only on cycles where the selected enable tap is high. In the free-running mode and the clear-on-match mode a new compare value takes effect at once. In the two pulse-width modes a write goes to a holding register, and the counter loads it when it reaches its maximum, so each period runs with one stable duty cycle. A one-shot force bit applies the compare action to the output without touching the counter or the flags. An enable output marks when the compare output should drive the pin in place of its normal function.

Top module: `wavetimer8`

## Requirements
- R1: Register port addresses: 0 control, 1 compare, 2 count (read only), 3 flags. The control byte holds force at bit 7, mode-low at bit 6, mode-high at bit 3, output action at bits 5:4 and clock select at bits 2:0. Mode = {bit3, bit6}: 0 free-run, 1 phase-correct, 2 clear-on-match, 3 fast. Every register resets to zero, and bit 7 of the control byte always reads 0.
- R2: Clock select 0 stops the counter. Code n (1..7) advances it only on cycles where tick[n-1] is high.
- R3: In mode 0 the counter counts up by one per step from 0 to 255 and wraps. The overflow flag (flags bit 0) sets on the step taken at 255.
- R4: In mode 2 the step taken when the count equals the compare value returns the count to 0. The overflow flag sets only on a step taken at 255.
- R5: In mode 3 the counter counts like mode 0. With action 2 the output clears on a match step and sets on the step at 255. Action 3 inverts both. Action 1 leaves the output unchanged. If a match step and the step at 255 coincide, the action for the step at 255 wins.
- R6: In mode 1 the counter counts 0 up to 255, then down to 0, with no repeated value. Action 2 clears the output on a match step while counting up and sets it on a match step while counting down. Action 3 inverts both. The overflow flag sets on the step taken at 0 while counting down.
- R7: In modes 0 and 2 a compare write is used from the next cycle. In modes 1 and 3 it is held and loaded on the step taken at 255, while reads of address 1 return the last written value.
- R8: In modes 0 and 2 a match step applies the output action: 1 toggles, 2 clears, 3 sets, 0 leaves the output unchanged.
- R9: A control write with bit 7 set and mode-low 0 applies the written action to the output (1 toggle, 2 clear, 3 set). It does not set the compare flag and does not reset the count. With mode-low 1 it has no effect.
- R10: cmp_oe is high whenever the stored action bits are nonzero.
- R11: The compare flag (flags bit 1) sets on the cycle after a step taken while the count equals the compare value.
- R12: Writing address 3 clears the overflow flag where data bit 0 is 1 and the compare flag where data bit 1 is 1. A flag that sets in the same cycle stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| tick | input | 7 | Clock-enable taps, selected by clock select |
| cmp_out | output | 1 | Waveform output |
| cmp_oe | output | 1 | Output override enable |
| ovf_flag | output | 1 | Overflow flag |
| cmp_flag | output | 1 | Compare-match flag |

## Verification
Several properties are stated only for cycles with no register write, because a write to the control byte can change the mode or the clock tap in the same cycle. The force check also requires the counter to be stopped before and after the write, so that no real match can set the flag. The stimulus issues writes only at the points each sweep needs. Between writes it holds the control byte steady, so most of each run lies inside these conditions. The flag-clear property likewise assumes a stopped counter, and the stimulus clears flags only where no overflow can coincide.

// File: rtl/wavetimer8.sv
module wavetimer8 #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [7:0]   wr_data,
  input  logic [1:0]   rd_addr,
  output logic [W-1:0] rd_data,
  input  logic [6:0]   tick,
  output logic         cmp_out,
  output logic         cmp_oe,
  output logic         ovf_flag,
  output logic         cmp_flag
);
  localparam logic [W-1:0] MAX = {W{1'b1}};

  logic [7:0]   ctrl;
  logic [W-1:0] cnt, cmp_buf, cmp_act;
  logic         up, out_q, out_n;

  wire [1:0]   mode    = {ctrl[3], ctrl[6]};
  wire [1:0]   act     = ctrl[5:4];
  wire [2:0]   csel    = ctrl[2:0];
  wire         pwm     = ctrl[6];
  wire         step    = (csel != 3'd0) && tick[csel - 3'd1];
  wire [W-1:0] cmp_eff = pwm ? cmp_act : cmp_buf;
  wire         match   = (cnt == cmp_eff);
  wire         at_max  = (cnt == MAX);
  wire         at_bot  = (cnt == '0);
  wire         wr_ctrl = wr_en && wr_addr == 2'd0;
  wire         wr_cmp  = wr_en && wr_addr == 2'd1;
  wire         wr_flg  = wr_en && wr_addr == 2'd3;
  wire         force_q = wr_ctrl && wr_data[7] && !wr_data[6];
  wire         ovf_set = step && ((mode == 2'd1) ? (at_bot && !up) : at_max);
  wire         cmp_set = step && match;

  assign cmp_out  = out_q;
  assign cmp_oe   = |act;
  assign ovf_flag = ovf_set_q;
  assign cmp_flag = cmp_set_q;

  logic ovf_set_q, cmp_set_q;

  always_comb begin
    out_n = out_q;
    if (step && match) begin
      if (!pwm) begin
        case (act)
          2'd1:    out_n = ~out_q;
          2'd2:    out_n = 1'b0;
          2'd3:    out_n = 1'b1;
          default: out_n = out_q;
        endcase
      end else if (act[1]) begin
        if (mode == 2'd3) out_n = act[0];
        else              out_n = up ? act[0] : ~act[0];
      end
    end
    if (mode == 2'd3 && step && at_max && act[1]) out_n = ~act[0];
    if (force_q) begin
      case (wr_data[5:4])
        2'd1:    out_n = ~out_n;
        2'd2:    out_n = 1'b0;
        2'd3:    out_n = 1'b1;
        default: out_n = out_n;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl      <= '0;
      cnt       <= '0;
      cmp_buf   <= '0;
      cmp_act   <= '0;
      up        <= 1'b1;
      out_q     <= 1'b0;
      ovf_set_q <= 1'b0;
      cmp_set_q <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl <= {1'b0, wr_data[6:0]};
      if (wr_cmp)  cmp_buf <= wr_data[W-1:0];
      if (!pwm || (step && at_max)) cmp_act <= cmp_buf;
      if (step) begin
        case (mode)
          2'd2: cnt <= match ? '0 : cnt + 1'b1;
          2'd1: begin
            if (up) begin
              if (at_max) begin cnt <= MAX - 1'b1; up <= 1'b0; end
              else cnt <= cnt + 1'b1;
            end else begin
              if (at_bot) begin cnt <= {{(W-1){1'b0}}, 1'b1}; up <= 1'b1; end
              else cnt <= cnt - 1'b1;
            end
          end
          default: cnt <= cnt + 1'b1;
        endcase
      end
      out_q     <= out_n;
      ovf_set_q <= ovf_set | (ovf_set_q & ~(wr_flg & wr_data[0]));
      cmp_set_q <= cmp_set | (cmp_set_q & ~(wr_flg & wr_data[1]));
    end
  end

  always_comb begin
    case (rd_addr)
      2'd0:    rd_data = W'(ctrl);
      2'd1:    rd_data = cmp_buf;
      2'd2:    rd_data = cnt;
      default: rd_data = W'({cmp_set_q, ovf_set_q});
    endcase
  end
endmodule

module wavetimer8_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic [1:0]   wr_addr,
  input logic [7:0]   wr_data,
  input logic [1:0]   rd_addr,
  input logic [W-1:0] rd_data,
  input logic         cmp_out,
  input logic         cmp_oe,
  input logic         ovf_flag,
  input logic         cmp_flag,
  input logic [7:0]   ctrl,
  input logic [W-1:0] cnt,
  input logic [W-1:0] cmp_act,
  input logic         up,
  input logic         step,
  input logic         match
);
  wire [1:0] mode = {ctrl[3], ctrl[6]};

  assert_ctrl_readback_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd0) |=> (rd_addr != 2'd0 ||
      (rd_data[7:0] == {1'b0, $past(wr_data[6:0])})));

  assert_stopped_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[2:0] == 3'd0 && !wr_en) |=> $stable(cnt));

  assert_freerun_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && step && !wr_en) |=> (cnt == $past(cnt) + 1'b1));

  assert_ctc_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && step && match && !wr_en) |=> (cnt == '0));

  assert_fast_set_at_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 && ctrl[5:4] == 2'd2 && step && cnt == {W{1'b1}} && !wr_en) |=> cmp_out);

  assert_phase_bottom_ovf_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && step && cnt == '0 && !up) |=> ovf_flag);

  assert_pwm_cmp_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[6] && !wr_en && !(step && cnt == {W{1'b1}})) |=> $stable(cmp_act));

  assert_nonpwm_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && ctrl[5:4] == 2'd3 && step && match && !wr_en) |=> cmp_out);

  assert_force_no_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd0 && wr_data[7] && !wr_data[6] && wr_data[2:0] == 3'd0 &&
     ctrl[2:0] == 3'd0 && !cmp_flag) |=> !cmp_flag);

  assert_override_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd0 && wr_data[5:4] != 2'd0) |=> cmp_oe);

  assert_cmp_flag_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmp_flag) |-> $past(step && match));

  assert_flag_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd3 && wr_data[0] && ctrl[2:0] == 3'd0) |=> !ovf_flag);
endmodule

bind wavetimer8 wavetimer8_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_addr(rd_addr), .rd_data(rd_data), .cmp_out(cmp_out), .cmp_oe(cmp_oe),
  .ovf_flag(ovf_flag), .cmp_flag(cmp_flag), .ctrl(ctrl), .cnt(cnt),
  .cmp_act(cmp_act), .up(up), .step(step), .match(match)
);

// File: tb/wavetimer8_tb_top.sv
module wavetimer8_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [1:0] rd_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [6:0] tick = 7'h7F;
  wire  [7:0] rd_data;
  wire        cmp_out, cmp_oe, ovf_flag, cmp_flag;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  wavetimer8 #(.W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .tick(tick), .cmp_out(cmp_out),
    .cmp_oe(cmp_oe), .ovf_flag(ovf_flag), .cmp_flag(cmp_flag)
  );

  task automatic check(string req, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  task automatic cyc(bit we = 1'b0, logic [1:0] a = 2'd0, logic [7:0] d = 8'd0);
    wr_en = we; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output int v);
    rd_addr = a; #1; v = rd_data;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #1600000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int v, c0, ex;
    @(negedge clk);
    do_reset();
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v); check("R1 reset register", v, 0);
    end
    check("R10 reset oe", cmp_oe, 0);
    check("R1 reset out", cmp_out, 0);

    // free-running, set on match, sweep past one wrap
    cyc(1, 2'd1, 8'd100);
    cyc(1, 2'd0, 8'h31);
    check("R10 oe on", cmp_oe, 1);
    for (int k = 1; k <= 300; k++) begin
      cyc();
      rd(2'd2, v); check("R3 count", v, k % 256);
      check("R3 ovf", ovf_flag, (k >= 256) ? 1 : 0);
      check("R11 cmp flag", cmp_flag, (k >= 101) ? 1 : 0);
      check("R8 set on match", cmp_out, (k >= 101) ? 1 : 0);
    end
    cyc(1, 2'd3, 8'h02);
    check("R12 clear cmp only", cmp_flag, 0);
    check("R12 ovf kept", ovf_flag, 1);
    cyc(1, 2'd3, 8'h01);
    check("R12 clear ovf", ovf_flag, 0);

    // stop
    cyc(1, 2'd0, 8'h00);
    check("R10 oe off", cmp_oe, 0);
    rd(2'd2, c0);
    for (int i = 0; i < 20; i++) cyc();
    rd(2'd2, v); check("R2 stopped", v, c0);

    // tap select
    cyc(1, 2'd0, 8'h03);
    rd(2'd2, c0);
    for (int i = 0; i < 40; i++) begin
      tick = (i % 4 == 0) ? 7'b0000100 : 7'b1111011;
      cyc();
    end
    tick = 7'h7F;
    rd(2'd2, v); check("R2 tap 3 steps", v, (c0 + 10) % 256);

    // clear-on-match with toggle and immediate compare change
    do_reset();
    cyc(1, 2'd1, 8'd9);
    cyc(1, 2'd0, 8'h19);
    for (int k = 1; k <= 60; k++) begin
      cyc(k == 51, 2'd1, 8'd4);
      ex = (k <= 50) ? (k % 10) : ((k - 50) % 5);
      rd(2'd2, v); check("R4 R7 ctc count", v, ex);
      if (k <= 50) check("R8 toggle", cmp_out, (k / 10) % 2);
      check("R11 cmp flag ctc", cmp_flag, (k >= 10) ? 1 : 0);
    end
    check("R4 no ovf", ovf_flag, 0);

    // force strobe
    do_reset();
    cyc(1, 2'd0, 8'hB0);
    check("R9 force set", cmp_out, 1);
    rd(2'd0, v); check("R1 force reads 0", v, 8'h30);
    cyc(1, 2'd0, 8'hA0);
    check("R9 force clear", cmp_out, 0);
    cyc(1, 2'd0, 8'h90);
    check("R9 force toggle", cmp_out, 1);
    cyc(1, 2'd0, 8'h90);
    check("R9 force toggle back", cmp_out, 0);
    cyc(1, 2'd0, 8'hF8);
    check("R9 force ignored in pwm", cmp_out, 0);
    check("R9 no flag", cmp_flag, 0);
    do_reset();
    cyc(1, 2'd1, 8'd50);
    cyc(1, 2'd0, 8'h19);
    for (int i = 0; i < 20; i++) cyc();
    cyc(1, 2'd0, 8'h99);
    rd(2'd2, v); check("R9 ctc not cleared", v, 21);
    check("R9 ctc force toggles", cmp_out, 1);
    check("R9 ctc no flag", cmp_flag, 0);

    // fast mode, non-inverting, buffered compare
    do_reset();
    cyc(1, 2'd1, 8'd64);
    cyc(1, 2'd0, 8'h69);
    for (int k = 1; k <= 800; k++) begin
      cyc(k == 300, 2'd1, 8'd200);
      if (k < 256) ex = 0;
      else if (k < 321) ex = 1;
      else if (k < 512) ex = 0;
      else if (k < 713) ex = 1;
      else if (k < 768) ex = 0;
      else ex = 1;
      check("R5 R7 fast out", cmp_out, ex);
      if (k == 255 || k == 256) check("R5 fast ovf", ovf_flag, (k == 256) ? 1 : 0);
    end
    rd(2'd1, v); check("R7 cmp readback", v, 200);

    // fast mode, reserved action
    do_reset();
    cyc(1, 2'd1, 8'd64);
    cyc(1, 2'd0, 8'h59);
    for (int k = 1; k <= 300; k++) begin
      cyc();
      check("R5 reserved out", cmp_out, 0);
    end
    check("R10 reserved oe", cmp_oe, 1);

    // fast mode, inverting
    do_reset();
    cyc(1, 2'd1, 8'd64);
    cyc(1, 2'd0, 8'h79);
    for (int k = 1; k <= 300; k++) begin
      cyc();
      check("R5 inverting out", cmp_out, (k >= 65 && k < 256) ? 1 : 0);
    end

    // phase-correct
    do_reset();
    cyc(1, 2'd1, 8'd100);
    cyc(1, 2'd0, 8'h61);
    for (int k = 1; k <= 700; k++) begin
      int m;
      cyc();
      m = k % 510;
      rd(2'd2, v); check("R6 phase count", v, (m <= 255) ? m : 510 - m);
      check("R6 phase out", cmp_out, (k >= 411 && k < 611) ? 1 : 0);
      check("R6 phase ovf", ovf_flag, (k >= 511) ? 1 : 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule